// File: doc/BRIEF.md
# Pipelined Shift-Accumulate Unit

This block is the shifter of a DSP data path. It takes a 36-bit operand and moves it left or right by an amount that comes from either an immediate field or a register field. The caller picks the source for each operation. A right shift is either logical, which fills with zeros, or arithmetic, which fills with copies of bit 35. The shift is done in the first of two pipeline stages. The second stage can then add the shifted value to an accumulator value that arrives with the operation.

Operations come in two sizes. A short (16-bit class) operation holds the first stage for one cycle, so a new one can be accepted every cycle. A long (32-bit class) operation holds the first stage for two cycles and arrives one cycle later. While a long operation holds the first stage, the unit tells the issuer it cannot take a new operation. In both sizes the shift acts on the full 36-bit operand; the size sets only occupancy and latency. Instruction decode, register storage and saturation are handled elsewhere.

Top module: `shift_acc_unit`

## Requirements
- R1: While reset is asserted, and on the first cycles after its release, `res_valid` is 0 and `ready` is 1.
- R2: When `amt_sel` is 1 the shift count is `reg_amt`, otherwise `imm_amt`; the unused field has no effect on the result.
- R3: With `dir_left`=1 the operand moves toward bit 35 and zeros enter at bit 0, whatever the value of `arith`; a count of 36 or more gives zero.
- R4: With `dir_left`=0 and `arith`=0 the operand moves toward bit 0 and zeros enter at bit 35; a count of 36 or more gives zero.
- R5: With `dir_left`=0 and `arith`=1 the vacated upper bits take the value of operand bit 35; a count of 36 or more gives 36 copies of bit 35.
- R6: An operation with `is_long`=0 that is accepted (`issue_valid` and `ready` both 1 at a rising edge) in cycle c has `res_valid`=1 with its result in cycle c+2, and such operations may be accepted in consecutive cycles.
- R7: An accepted operation with `is_long`=1 in cycle c has `res_valid`=1 with its result in cycle c+3.
- R8: `ready` is 0 for exactly the one cycle after a long operation is accepted; an `issue_valid` presented in that cycle is ignored and produces no result.
- R9: With `acc_en`=1 the result is the shifted value plus `acc_in` modulo 2^36 (no saturation); with `acc_en`=0 the result is the shifted value alone.
- R10: `res_valid` is 1 only in cycles where an accepted operation's result is due; results appear in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_valid | input | 1 | An operation is offered this cycle |
| operand | input | 36 | Value to shift |
| imm_amt | input | 6 | Immediate shift count |
| reg_amt | input | 6 | Register shift count |
| amt_sel | input | 1 | 1 selects `reg_amt`, 0 selects `imm_amt` |
| arith | input | 1 | 1 arithmetic, 0 logical |
| dir_left | input | 1 | 1 left, 0 right |
| is_long | input | 1 | 1 for a 32-bit class operation |
| acc_en | input | 1 | Add the shifted value to `acc_in` in stage two |
| acc_in | input | 36 | Accumulator value carried with the operation |
| ready | output | 1 | Unit accepts an operation this cycle |
| res_valid | output | 1 | `result` holds a finished operation |
| result | output | 36 | Shifted or accumulated value |

## Verification
The checker takes it for granted that `issue_valid` and `is_long` are never unknown after reset. It also assumes that no operation is offered during the two cycles the internal reset takes to release, since the latency properties count from acceptance at the port. The bench holds every input at 0 through reset and waits several idle cycles before its first operation. After that it drives only defined values. It keeps offering operations while `ready` is low, so the ignored-issue case is exercised.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic [1:0] {
    SH_LEFT = 2'd0,
    SH_RLOG = 2'd1,
    SH_RARI = 2'd2
  } sh_kind_e;

  function automatic sh_kind_e sa_decode(input logic left, input logic arith);
    if (left)       return SH_LEFT;
    else if (arith) return SH_RARI;
    else            return SH_RLOG;
  endfunction
endpackage

// File: rtl/sa_barrel.sv
module sa_barrel
  import sa_pkg::*;
#(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] amt,
  input  sh_kind_e      kind,
  output logic [DW-1:0] dout
);
  logic          fill;
  logic [DW-1:0] lvl [0:AW];

  assign fill   = (kind == SH_RARI) ? din[DW-1] : 1'b0;
  assign lvl[0] = din;

  for (genvar i = 0; i < AW; i++) begin : g_lvl
    localparam int STEP = 1 << i;
    logic [DW-1:0] moved;
    if (STEP >= DW) begin : g_full
      assign moved = (kind == SH_LEFT) ? '0 : {DW{fill}};
    end else begin : g_part
      assign moved = (kind == SH_LEFT) ? {lvl[i][DW-1-STEP:0], {STEP{1'b0}}}
                                       : {{STEP{fill}}, lvl[i][DW-1:STEP]};
    end
    assign lvl[i+1] = amt[i] ? moved : lvl[i];
  end

  assign dout = lvl[AW];
endmodule

// File: rtl/sa_issue_stage.sv
module sa_issue_stage #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  input  logic          is_long,
  input  logic          acc_en,
  input  logic [DW-1:0] shifted,
  input  logic [DW-1:0] acc_in,
  output logic          ready,
  output logic          fwd_valid,
  output logic [DW-1:0] fwd_data,
  output logic [DW-1:0] fwd_acc,
  output logic          fwd_acc_en
);
  logic          vld_q, vld_d;
  logic          hold_q, hold_d;
  logic          load_en;
  logic [DW-1:0] data_q, acc_q;
  logic          acce_q;

  assign ready   = !(vld_q && hold_q);
  assign load_en = ready && issue_valid;

  always_comb begin
    vld_d  = vld_q;
    hold_d = hold_q;
    if (!ready) begin
      hold_d = 1'b0;
    end else begin
      vld_d  = issue_valid;
      hold_d = issue_valid && is_long;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      acc_q  <= '0;
      acce_q <= 1'b0;
    end else if (load_en) begin
      data_q <= shifted;
      acc_q  <= acc_in;
      acce_q <= acc_en;
    end
  end

  assign fwd_valid  = vld_q && !hold_q;
  assign fwd_data   = data_q;
  assign fwd_acc    = acc_q;
  assign fwd_acc_en = acce_q;
endmodule

// File: rtl/sa_accum_stage.sv
module sa_accum_stage #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [DW-1:0] in_acc,
  input  logic          in_acc_en,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic          vld_q;
  logic [DW-1:0] res_q, res_d;

  always_comb begin
    res_d = in_acc_en ? (in_data + in_acc) : in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (in_valid) res_q <= res_d;
  end

  assign out_valid = vld_q;
  assign out_data  = res_q;
endmodule

// File: rtl/shift_acc_unit.sv
module shift_acc_unit
  import sa_pkg::*;
#(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  input  logic [DW-1:0] operand,
  input  logic [AW-1:0] imm_amt,
  input  logic [AW-1:0] reg_amt,
  input  logic          amt_sel,
  input  logic          arith,
  input  logic          dir_left,
  input  logic          is_long,
  input  logic          acc_en,
  input  logic [DW-1:0] acc_in,
  output logic          ready,
  output logic          res_valid,
  output logic [DW-1:0] result
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync;
  logic              rst_int_n;
  logic [AW-1:0]     amt;
  sh_kind_e          kind;
  logic [DW-1:0]     shifted;
  logic              s1_valid, s1_acc_en;
  logic [DW-1:0]     s1_data, s1_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync[SYNC_N-1];

  assign amt  = amt_sel ? reg_amt : imm_amt;
  assign kind = sa_decode(dir_left, arith);

  sa_barrel #(.DW(DW), .AW(AW)) u_shift (
    .din (operand),
    .amt (amt),
    .kind(kind),
    .dout(shifted)
  );

  sa_issue_stage #(.DW(DW)) u_st1 (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .issue_valid(issue_valid),
    .is_long    (is_long),
    .acc_en     (acc_en),
    .shifted    (shifted),
    .acc_in     (acc_in),
    .ready      (ready),
    .fwd_valid  (s1_valid),
    .fwd_data   (s1_data),
    .fwd_acc    (s1_acc),
    .fwd_acc_en (s1_acc_en)
  );

  sa_accum_stage #(.DW(DW)) u_st2 (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_valid (s1_valid),
    .in_data  (s1_data),
    .in_acc   (s1_acc),
    .in_acc_en(s1_acc_en),
    .out_valid(res_valid),
    .out_data (result)
  );
endmodule

// File: rtl/shift_acc_unit_chk.sv
module shift_acc_unit_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue_valid,
  input logic          is_long,
  input logic          ready,
  input logic          res_valid,
  input logic [DW-1:0] result
);
  // R8
  long_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && ready && is_long) |=> !ready);

  // R8
  stall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ready);

  // R8
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> $past(issue_valid && ready && is_long));

  // R6
  short_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && ready && !is_long) |-> ##2 res_valid);

  // R7
  long_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && ready && is_long) |-> ##3 res_valid);

  // R7
  long_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && ready && is_long) |-> ##2 !res_valid);

  // R10
  result_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !$isunknown(result));
endmodule

bind shift_acc_unit shift_acc_unit_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue_valid(issue_valid),
  .is_long    (is_long),
  .ready      (ready),
  .res_valid  (res_valid),
  .result     (result)
);

// File: tb/sim_shift_acc_unit.sv
`timescale 1ns/1ps
module sim_shift_acc_unit;
  localparam int DW = 36;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          issue_valid;
  logic [DW-1:0] operand;
  logic [AW-1:0] imm_amt, reg_amt;
  logic          amt_sel, arith, dir_left, is_long, acc_en;
  logic [DW-1:0] acc_in;
  logic          ready, res_valid;
  logic [DW-1:0] result;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  int long_edge = -10;
  bit finished = 1'b0;

  typedef struct {
    int            due;
    logic [DW-1:0] val;
    string         tag;
  } exp_t;
  exp_t expq[$];

  always #10 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  shift_acc_unit #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .operand(operand),
    .imm_amt(imm_amt), .reg_amt(reg_amt), .amt_sel(amt_sel), .arith(arith),
    .dir_left(dir_left), .is_long(is_long), .acc_en(acc_en), .acc_in(acc_in),
    .ready(ready), .res_valid(res_valid), .result(result)
  );

  function automatic logic [DW-1:0] model(logic [DW-1:0] v, int n, bit ar, bit lf);
    logic signed [DW-1:0] sv;
    sv = v;
    if (lf)      return (n >= DW) ? '0 : (v << n);
    else if (ar) return (n >= DW) ? {DW{v[DW-1]}} : DW'(sv >>> n);
    else         return (n >= DW) ? '0 : (v >> n);
  endfunction

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at edge %0d", tag, act, exp, edges);
    end
  endtask

  task automatic compare();
    bit ev;
    ev = (expq.size() > 0) && (expq[0].due == edges);
    chk(ready === (long_edge != edges), "R8 ready", DW'(ready), DW'(long_edge != edges));
    chk(res_valid === ev, "R6 R7 R10 res_valid", DW'(res_valid), DW'(ev));
    if (ev) begin
      chk(result === expq[0].val, expq[0].tag, result, expq[0].val);
      void'(expq.pop_front());
    end
  endtask

  task automatic step(bit v, logic [DW-1:0] op, logic [AW-1:0] im, logic [AW-1:0] ra,
                      bit sel, bit ar, bit lf, bit lg, bit ae, logic [DW-1:0] acc);
    exp_t e;
    int n;
    @(negedge clk);
    compare();
    issue_valid = v; operand = op; imm_amt = im; reg_amt = ra; amt_sel = sel;
    arith = ar; dir_left = lf; is_long = lg; acc_en = ae; acc_in = acc;
    if (v && ready) begin
      n = sel ? int'(ra) : int'(im);
      e.val = model(op, n, ar, lf);
      if (ae) e.val = e.val + acc;
      e.due = edges + (lg ? 3 : 2);
      e.tag = lf ? "R3 left" : (ar ? "R5 arith right" : "R4 logical right");
      if (sel) e.tag = {e.tag, " R2 reg count"};
      if (ae)  e.tag = {e.tag, " R9 acc"};
      e.tag = {e.tag, lg ? " R7 long" : " R6 short"};
      expq.push_back(e);
      if (lg) long_edge = edges + 1;
    end
  endtask

  task automatic idle();
    step(1'b0, '0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired, actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    issue_valid = 1'b0; operand = '0; imm_amt = '0; reg_amt = '0; amt_sel = 1'b0;
    arith = 1'b0; dir_left = 1'b0; is_long = 1'b0; acc_en = 1'b0; acc_in = '0;
    repeat (3) begin
      @(negedge clk);
      chk(res_valid === 1'b0 && ready === 1'b1, "R1 reset", {ready, res_valid}, 2'b10);
    end
    rst_n = 1'b1;
    repeat (4) idle();
    // R3 left, including counts 0, 35, 36, 63 and arith set
    step(1, 36'h0_0000_0001, 6'd0,  6'd9,  0, 0, 1, 0, 0, '0);
    step(1, 36'h0_0000_0001, 6'd35, 6'd0,  0, 1, 1, 0, 0, '0);
    step(1, 36'hF_FFFF_FFFF, 6'd36, 6'd0,  0, 0, 1, 0, 0, '0);
    step(1, 36'hA_BCDE_F123, 6'd4,  6'd63, 1, 0, 1, 0, 0, '0);
    // R4 logical right
    step(1, 36'h8_0000_0000, 6'd35, 6'd1,  0, 0, 0, 0, 0, '0);
    step(1, 36'h8_0000_0000, 6'd7,  6'd36, 1, 0, 0, 0, 0, '0);
    // R5 arithmetic right
    step(1, 36'h8_0000_0000, 6'd1,  6'd0,  0, 1, 0, 0, 0, '0);
    step(1, 36'h8_1234_5678, 6'd63, 6'd0,  0, 1, 0, 0, 0, '0);
    step(1, 36'h7_FFFF_FFFF, 6'd0,  6'd40, 1, 1, 0, 0, 0, '0);
    // R9 accumulate with wraparound
    step(1, 36'hF_FFFF_FFFF, 6'd0,  6'd0,  0, 0, 1, 0, 1, 36'h0_0000_0002);
    step(1, 36'h0_0000_0010, 6'd2,  6'd0,  0, 1, 0, 0, 1, 36'h8_0000_0000);
    // R7 R8 long ops back to back, issue held while not ready
    step(1, 36'h1_2345_6789, 6'd8,  6'd0,  0, 0, 1, 1, 0, '0);
    step(1, 36'h5_5555_5555, 6'd3,  6'd0,  0, 0, 0, 1, 1, 36'h1);
    step(1, 36'hC_0000_0000, 6'd2,  6'd0,  0, 1, 0, 1, 0, '0);
    step(1, 36'h0_0000_00FF, 6'd1,  6'd0,  0, 0, 1, 0, 0, '0);
    step(1, 36'h0_0000_00FF, 6'd2,  6'd0,  0, 0, 1, 0, 0, '0);
    repeat (4) idle();
    for (int i = 0; i < 2000; i++) begin
      logic [DW-1:0] r1, r2;
      int p;
      r1 = {$urandom, $urandom};
      r2 = {$urandom, $urandom};
      p = $urandom_range(0, 9);
      step(p < 7, r1, AW'($urandom), AW'($urandom), $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, r2);
    end
    repeat (5) idle();
    chk(expq.size() == 0, "R10 drained", DW'(expq.size()), '0);
    finish_run();
  end
endmodule